// File: doc/BRIEF.md
# Windowed Trigger Watchdog with Hysteresis

This block supervises a host processor through a periodic trigger line. On each rising edge of the trigger it measures how many time-base ticks have passed since the previous accepted edge, and it judges that interval as good or bad against a time window. A saturating score from 0 to 3, together with a fault flag, decides whether the OK output is asserted. A good interval raises the score by one and a bad interval lowers it by one. OK turns on only when the score reaches 3 and turns off only when the score falls back to 0. The window edges also move by one tick depending on the OK state. Both effects give hysteresis.

The time base reaches the block as a one-cycle enable `tick_i` in the fast clock domain, nominally at 100 times the trigger rate. The trigger is asynchronous and is synchronized inside the block. If the trigger stays silent for 250 ticks, the watchdog drops its score to 0. An oscillator-error input and a synchronous supervisor reset also force the failed state, so a stopped time base cannot freeze the verdict.

Top module: `trig_window_wdog`

## Requirements
- R1: `trig_i` passes through two synchronizer flops and then an edge detector. When `trig_i` is first sampled high at clock edge k, the resulting score update is visible after edge k+2 and not before.
- R2: The score moves up by 1 on a good interval and down by 1 on a bad interval. It saturates at 3 on a good interval and at 0 on a bad interval.
- R3: `ok_o` rises only when the score reaches 3 and falls only when the score reaches 0. In states 1 and 2 it keeps its previous value.
- R4: After any reset the score is 0 and `ok_o` is 0. Three good intervals in a row are needed before `ok_o` rises.
- R5: While `ok_o` is 0, an interval of 80 to 170 ticks inclusive is good. Any other interval is bad.
- R6: While `ok_o` is 1, an interval of 79 to 169 ticks inclusive is good. Any other interval is bad.
- R7: The interval is the number of cycles with `tick_i` high since the previous detected edge, or since the last reset. A tick in the cycle of an edge is not counted.
- R8: When the interval count reaches 250, the score becomes 0 and `ok_o` becomes 0 on the next clock. A count of 249 has no effect.
- R9: The interval count saturates at 251 and does not wrap. A trigger after 356 ticks is therefore judged bad.
- R10: When `osc_err_i` is high at a clock edge, the score is 0 and `ok_o` is 0 after that edge. The interval count is left unchanged.
- R11: When `sync_rst_i` is high at a clock edge, the score, `ok_o` and the interval count are all cleared at that edge.
- R12: When `rst_ni` is low, the block is immediately in the reset state (score 0, `ok_o` 0), without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick enable, one cycle wide |
| trig_i | input | 1 | Asynchronous trigger from the host |
| sync_rst_i | input | 1 | Synchronous reset from the supply supervisor |
| osc_err_i | input | 1 | Time-base failure indication |
| ok_o | output | 1 | Watchdog OK flag |
| score_o | output | 2 | Current score, 0 to 3 |

## Verification
Score and OK updates that come from a trigger appear two clocks after the first clock that samples the trigger high. The bench holds each trigger pulse for four cycles and then waits four more, and it samples only after that. The R1 case is the exception: it samples on the falling edge after the second and after the third clock. The timeout, oscillator-error and synchronous-reset effects show up one clock after their cause, so those checks are made at the falling edge that follows. The asynchronous reset check is taken one time step after `rst_ni` falls, with no clock edge in between.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_GOOD = 2'd1,
    VERDICT_BAD  = 2'd2
  } verdict_e;
endpackage

// File: rtl/wdw_trig_sync.sv
module wdw_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= trig_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign edge_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wdw_interval_ctr.sv
module wdw_interval_ctr #(
  parameter int CW      = 8,
  parameter int SAT     = 251,
  parameter int TIMEOUT = 250
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          edge_i,
  input  logic          tick_i,
  output logic [CW-1:0] count_o,
  output logic          timeout_o
);
  localparam logic [CW-1:0] SatVal = CW'(SAT);
  localparam logic [CW-1:0] ToVal  = CW'(TIMEOUT);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       count_q <= '0;
    else if (clear_i || edge_i)        count_q <= '0;
    else if (tick_i && count_q != SatVal) count_q <= count_q + 1'b1;
  end

  assign count_o   = count_q;
  assign timeout_o = (count_q >= ToVal);
endmodule

// File: rtl/wdw_window_judge.sv
module wdw_window_judge
  import wdw_pkg::*;
#(
  parameter int CW     = 8,
  parameter int WIN_LO = 80,
  parameter int WIN_HI = 170,
  parameter int SHIFT  = 1
) (
  input  logic          edge_i,
  input  logic          ok_i,
  input  logic [CW-1:0] count_i,
  output verdict_e      verdict_o
);
  localparam logic [CW-1:0] LoNok = CW'(WIN_LO);
  localparam logic [CW-1:0] HiNok = CW'(WIN_HI);
  localparam logic [CW-1:0] LoOk  = CW'(WIN_LO - SHIFT);
  localparam logic [CW-1:0] HiOk  = CW'(WIN_HI - SHIFT);

  logic [CW-1:0] lo, hi;

  // hysteresis: window moves earlier by SHIFT while OK is held
  always_comb begin
    lo = ok_i ? LoOk : LoNok;
    hi = ok_i ? HiOk : HiNok;
    if (!edge_i)                         verdict_o = VERDICT_NONE;
    else if (count_i >= lo && count_i <= hi) verdict_o = VERDICT_GOOD;
    else                                 verdict_o = VERDICT_BAD;
  end
endmodule

// File: rtl/wdw_score.sv
module wdw_score
  import wdw_pkg::*;
#(
  parameter int SCORE_MAX = 3,
  localparam int SW = $clog2(SCORE_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  verdict_e      verdict_i,
  output logic [SW-1:0] score_o,
  output logic          ok_o
);
  localparam logic [SW-1:0] Top = SW'(SCORE_MAX);
  localparam logic [SW-1:0] One = SW'(1);

  logic [SW-1:0] score_q;
  logic          fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      score_q <= '0;
      fault_q <= 1'b1;
    end else if (clear_i) begin
      score_q <= '0;
      fault_q <= 1'b1;
    end else begin
      case (verdict_i)
        VERDICT_GOOD: if (score_q != Top) begin
          score_q <= score_q + 1'b1;
          if (score_q == Top - One) fault_q <= 1'b0;
        end
        VERDICT_BAD: if (score_q != '0) begin
          score_q <= score_q - 1'b1;
          if (score_q == One) fault_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign score_o = score_q;
  assign ok_o    = ~fault_q;
endmodule

// File: rtl/trig_window_wdog.sv
module trig_window_wdog
  import wdw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LO      = 80,
  parameter int WIN_HI      = 170,
  parameter int WIN_SHIFT   = 1,
  parameter int TIMEOUT     = 250,
  parameter int SCORE_MAX   = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           tick_i,
  input  logic                           trig_i,
  input  logic                           sync_rst_i,
  input  logic                           osc_err_i,
  output logic                           ok_o,
  output logic [$clog2(SCORE_MAX+1)-1:0] score_o
);
  localparam int SatCount = TIMEOUT + 1;
  localparam int CW       = $clog2(SatCount + 1);

  logic          trig_edge;
  logic [CW-1:0] count;
  logic          timeout;
  logic          score_clear;
  verdict_e      verdict;

  wdw_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(trig_i),
    .edge_o(trig_edge)
  );

  wdw_interval_ctr #(.CW(CW), .SAT(SatCount), .TIMEOUT(TIMEOUT)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (sync_rst_i),
    .edge_i   (trig_edge),
    .tick_i   (tick_i),
    .count_o  (count),
    .timeout_o(timeout)
  );

  wdw_window_judge #(.CW(CW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .SHIFT(WIN_SHIFT)) u_judge (
    .edge_i   (trig_edge),
    .ok_i     (ok_o),
    .count_i  (count),
    .verdict_o(verdict)
  );

  assign score_clear = sync_rst_i | osc_err_i | timeout;

  wdw_score #(.SCORE_MAX(SCORE_MAX)) u_score (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (score_clear),
    .verdict_i(verdict),
    .score_o  (score_o),
    .ok_o     (ok_o)
  );
endmodule

// File: rtl/trig_window_wdog_chk.sv
module trig_window_wdog_chk #(
  parameter int SW = 2,
  parameter int SCORE_MAX = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sync_rst_i,
  input logic          osc_err_i,
  input logic          ok_o,
  input logic [SW-1:0] score_o
);
  logic [SW:0] cur_w;
  assign cur_w = {1'b0, score_o};

  // R2: score moves by at most one unless forced to zero
  p_single_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_w == $past(cur_w)) || (cur_w == '0) ||
    (cur_w == $past(cur_w) + 1'b1) || (cur_w + 1'b1 == $past(cur_w)));

  p_ok_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok_o) |-> (cur_w == (SW+1)'(SCORE_MAX)));

  p_ok_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ok_o) |-> (cur_w == '0));

  p_osc_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_err_i |=> (cur_w == '0 && !ok_o));

  p_sync_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> (cur_w == '0 && !ok_o));
endmodule

bind trig_window_wdog trig_window_wdog_chk #(
  .SW($clog2(SCORE_MAX+1)), .SCORE_MAX(SCORE_MAX)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_rst_i(sync_rst_i),
  .osc_err_i (osc_err_i),
  .ok_o      (ok_o),
  .score_o   (score_o)
);

// File: tb/trig_window_wdog_bench.sv
module trig_window_wdog_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       trig = 1'b0;
  logic       srst = 1'b0;
  logic       oerr = 1'b0;
  logic       ok;
  logic [1:0] score;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_window_wdog u_trig_window_wdog (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .trig_i(trig),
    .sync_rst_i(srst), .osc_err_i(oerr), .ok_o(ok), .score_o(score)
  );

  task automatic chk(string req, int exp_s, int exp_ok);
    checks++;
    if (int'(score) != exp_s || int'(ok) != exp_ok) begin
      failures++;
      $display("FAIL %s score=%0d ok=%0d expected score=%0d ok=%0d", req, score, ok, exp_s, exp_ok);
    end
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic pulse_trig();
    trig = 1'b1; repeat (4) @(negedge clk);
    trig = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic interval(int n, int exp_s, int exp_ok, string req);
    run_ticks(n);
    pulse_trig();
    chk(req, exp_s, exp_ok);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R4 reset state", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 after release", 0, 0);
  endtask

  // R1: three clocks from first sample to visible update; R7 counts from reset
  task automatic t_sync_latency();
    run_ticks(100);
    trig = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 not before third edge", 0, 0);
    @(negedge clk);
    chk("R1 update at third edge R7", 1, 0);
    trig = 1'b0; repeat (5) @(negedge clk);
  endtask

  task automatic t_climb();
    interval(100, 2, 0, "R4 second good");
    interval(100, 3, 1, "R4 third good sets ok R3");
    interval(100, 3, 1, "R2 saturate high");
  endtask

  task automatic t_window_ok();
    interval(170, 2, 1, "R6 170 bad while ok");
    interval(169, 3, 1, "R6 169 good");
    interval(170, 2, 1, "R6 170 bad again");
    interval(79, 3, 1, "R6 79 good");
    interval(78, 2, 1, "R6 78 bad");
    interval(50, 1, 1, "R3 ok held at 1");
    interval(50, 0, 0, "R3 ok clears at 0");
    interval(50, 0, 0, "R2 saturate low");
  endtask

  task automatic t_window_nok();
    interval(80, 1, 0, "R5 80 good");
    interval(170, 2, 0, "R5 170 good");
    interval(79, 1, 0, "R5 79 bad");
    interval(171, 0, 0, "R5 171 bad");
    interval(100, 1, 0, "R5 good");
    interval(100, 2, 0, "R3 ok stays low at 2");
    interval(100, 3, 1, "R5 reach 3");
  endtask

  task automatic t_hysteresis();
    interval(30, 2, 1, "R3 3 to 2");
    interval(30, 1, 1, "R3 2 to 1");
    interval(100, 2, 1, "R3 1 to 2 keeps ok");
    interval(100, 3, 1, "R3 back to 3");
  endtask

  task automatic t_timeout();
    run_ticks(249);
    chk("R8 249 no effect", 3, 1);
    run_ticks(1);
    chk("R8 250 clears", 0, 0);
  endtask

  task automatic t_saturation();
    interval(106, 0, 0, "R9 356 ticks bad");
    interval(100, 1, 0, "R7 count restarts after late edge");
  endtask

  task automatic t_osc_err();
    interval(100, 2, 0, "R10 setup");
    interval(100, 3, 1, "R10 setup ok");
    oerr = 1'b1; @(negedge clk);
    oerr = 1'b0;
    chk("R10 osc error clears", 0, 0);
    interval(100, 1, 0, "R10 count kept");
  endtask

  task automatic t_sync_rst();
    interval(100, 2, 0, "R11 setup");
    run_ticks(60);
    srst = 1'b1; @(negedge clk);
    srst = 1'b0;
    chk("R11 sync reset clears", 0, 0);
    interval(30, 0, 0, "R11 count cleared 30 bad");
  endtask

  task automatic t_async_rst();
    interval(100, 1, 0, "R12 setup");
    #1 rst_n = 1'b0;
    #1 chk("R12 async reset immediate", 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 released", 0, 0);
  endtask

  initial begin
    t_reset();
    t_sync_latency();
    t_climb();
    t_window_ok();
    t_window_nok();
    t_hysteresis();
    t_timeout();
    t_saturation();
    t_osc_err();
    t_sync_rst();
    t_async_rst();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule